// File: doc/BRIEF.md
# Colour Balance Matrix

The block corrects the colour of a pixel stream. Each incoming pixel carries red, green and blue components of `PIX_W` bits. Each corrected component is the dot product of the input vector with one row of a 3x3 coefficient matrix. Nine multipliers work side by side, so the block can take one pixel on every clock. The sum is rounded and then clamped to the component range. Coefficient sets are kept in `N_TBL` tables. The table in use is chosen through a plain select input, and a change of table happens only at a frame boundary. A write port loads any single coefficient of any table.

Both streams use valid/ready. A pixel is accepted on a clock edge where `s_valid` and `s_ready` are both high, and it is delivered on an edge where `m_valid` and `m_ready` are both high. Every pipeline stage moves forward together, and the pipeline freezes only while a result waits at the output. So `s_ready` is low exactly when `m_valid` is high and `m_ready` is low. A held output keeps its data until it is taken. The start-of-frame flag travels with its pixel.

Top module: `colour_balance_matrix`

## Requirements
- R1: After reset `m_valid` is low, `s_ready` is high, table 0 is the active table, and every table holds the identity matrix. All of tables 0 to 63 pass pixels through unchanged until they are written.
- R2: Coefficients are signed two's complement with 12 fraction bits (Q3.12, 16 bits). Component packing in `s_rgb` and `m_rgb` is red in the top `PIX_W` bits, green in the middle and blue at the bottom. Output component r is the sum over c of coef[r][c] times input component c, where index 0 is red, 1 is green and 2 is blue.
- R3: The row sum is rounded to the nearest integer, and an exact half rounds toward plus infinity. This is floor((sum + 2048) / 4096).
- R4: A rounded result below 0 gives 0, and a result above 2^PIX_W-1 gives 2^PIX_W-1.
- R5: With `m_ready` held high, a pixel accepted on edge k appears on `m_valid`/`m_rgb` after edge k+2, which is 3 clocks of latency. `m_sof` is high only with `m_valid`, and only for the pixel that was accepted with `s_sof`.
- R6: While `m_valid` is high and `m_ready` is low, `s_ready` is low and `m_valid`, `m_rgb` and `m_sof` hold their values. No pixel is lost or reordered.
- R7: `tbl_sel` is sampled only when a pixel with `s_sof` is accepted. That pixel and all later pixels use the sampled table until the next frame start. Changes to `tbl_sel` at other times have no effect.
- R8: A coefficient write (`cw_en` high for one clock) to a table other than the one in use is stored at once.
- R9: A write to the table in use is held back until the next accepted frame-start pixel. That pixel already uses the new value if it selects the same table. Pixels before it use the old value.
- R10: `cw_row` selects the output component and `cw_col` selects the input component, with 0 as red, 1 as green and 2 as blue. A write with row or column equal to 3 changes nothing.
- R11: When the output stage is empty or `m_ready` is high, `s_ready` is high, so a stream of back-to-back pixels is accepted at one pixel per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_sel | input | TBL_W | Table to use from the next frame start |
| cw_en | input | 1 | Coefficient write strobe |
| cw_tbl | input | TBL_W | Table addressed by the write |
| cw_row | input | 2 | Output component addressed by the write |
| cw_col | input | 2 | Input component addressed by the write |
| cw_data | input | COEF_W | Signed Q3.12 coefficient value |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block can accept a pixel |
| s_sof | input | 1 | Input pixel is the first of a frame |
| s_rgb | input | 3*PIX_W | Input pixel, red in top bits |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Consumer takes the output pixel |
| m_sof | output | 1 | Output pixel is the first of a frame |
| m_rgb | output | 3*PIX_W | Corrected pixel, red in top bits |

## Verification
The bench builds the block with its defaults: 8-bit components, Q3.12 coefficients and 64 tables. With 8-bit components, the clamp at 255 and at 0 can be reached with small coefficient values, and a gain of two moves the boundary between 127 and 128 into view. The full 6-bit table address lets the bench use both table 0 and table 63. Small integer pixels against coefficients of exactly one half give cases that land exactly on the rounding boundary, so the half-up rule can be checked for positive and negative sums.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  // Number of colour components per pixel
  localparam int N_CH = 3;

  // Component index used for rows and columns of the matrix
  typedef enum logic [1:0] {
    CH_R = 2'd0,
    CH_G = 2'd1,
    CH_B = 2'd2
  } ch_e;
endpackage

// File: rtl/cbm_coef_row.sv
// Coefficient store for one matrix row: every table's three coefficients of
// this row, plus a pending slot for writes aimed at the table in use.
module cbm_coef_row #(
  parameter int ROW    = 0,
  parameter int COEF_W = 16,
  parameter int FRAC   = 12,
  parameter int N_TBL  = 64,
  parameter int TBL_W  = 6
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [TBL_W-1:0]                        rd_tbl,
  input  logic                                    fwd,
  input  logic                                    commit,
  input  logic [TBL_W-1:0]                        act_tbl,
  input  logic                                    wr_en,
  input  logic                                    defer,
  input  logic [TBL_W-1:0]                        wr_tbl,
  input  logic [1:0]                              wr_col,
  input  logic [COEF_W-1:0]                       wr_data,
  output logic [cbm_pkg::N_CH-1:0][COEF_W-1:0]    coef_o
);
  import cbm_pkg::*;

  localparam logic [COEF_W-1:0] ONE = COEF_W'(1) << FRAC;

  logic [COEF_W-1:0]              mem [N_TBL][N_CH];
  logic [N_CH-1:0][COEF_W-1:0]    pend;
  logic [N_CH-1:0]                pmask;
  logic                           col_ok;

  assign col_ok = (wr_col != 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < N_TBL; t++) begin
        for (int c = 0; c < N_CH; c++) begin
          mem[t][c] <= (c == ROW) ? ONE : '0;
        end
      end
      pend  <= '0;
      pmask <= '0;
    end else begin
      // Frame start: held-back writes land in the table that was in use
      if (commit) begin
        for (int c = 0; c < N_CH; c++) begin
          if (pmask[c]) mem[act_tbl][c] <= pend[c];
        end
        pmask <= '0;
      end
      if (wr_en && col_ok) begin
        if (defer) begin
          pend[wr_col]  <= wr_data;
          pmask[wr_col] <= 1'b1;
        end else begin
          mem[wr_tbl][wr_col] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      coef_o[c] = (fwd && pmask[c]) ? pend[c] : mem[rd_tbl][c];
    end
  end
endmodule

// File: rtl/cbm_dot_row.sv
// One output component: three multipliers, an adder, then round and clamp.
module cbm_dot_row #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int FRAC   = 12
) (
  input  logic                                   clk,
  input  logic                                   adv,
  input  logic [cbm_pkg::N_CH-1:0][PIX_W-1:0]    pix_i,
  input  logic [cbm_pkg::N_CH-1:0][COEF_W-1:0]   coef_i,
  output logic [PIX_W-1:0]                       out_o
);
  import cbm_pkg::*;

  localparam int PROD_W = PIX_W + 1 + COEF_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC - 1);
  localparam logic signed [SUM_W-1:0] TOP  = SUM_W'((1 << PIX_W) - 1);

  logic signed [PROD_W-1:0] prod [N_CH];
  logic signed [PROD_W-1:0] a_ext [N_CH];
  logic signed [PROD_W-1:0] c_ext [N_CH];
  logic signed [SUM_W-1:0]  sum;
  logic signed [SUM_W-1:0]  rnd;
  logic signed [SUM_W-1:0]  shr;
  logic [PIX_W-1:0]         sat;

  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      a_ext[c] = PROD_W'($signed({1'b0, pix_i[c]}));
      c_ext[c] = PROD_W'($signed(coef_i[c]));
    end
  end

  always_comb begin
    rnd = sum + HALF;
    shr = rnd >>> FRAC;
    if (shr < 0)        sat = '0;
    else if (shr > TOP) sat = '1;
    else                sat = shr[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int c = 0; c < N_CH; c++) begin
        prod[c] <= a_ext[c] * c_ext[c];
      end
      sum   <= SUM_W'(prod[0]) + SUM_W'(prod[1]) + SUM_W'(prod[2]);
      out_o <= sat;
    end
  end
endmodule

// File: rtl/colour_balance_matrix.sv
module colour_balance_matrix #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int FRAC   = 12,
  parameter int N_TBL  = 64,
  localparam int TBL_W = $clog2(N_TBL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TBL_W-1:0]   tbl_sel,
  input  logic               cw_en,
  input  logic [TBL_W-1:0]   cw_tbl,
  input  logic [1:0]         cw_row,
  input  logic [1:0]         cw_col,
  input  logic [COEF_W-1:0]  cw_data,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic               s_sof,
  input  logic [3*PIX_W-1:0] s_rgb,
  output logic               m_valid,
  input  logic               m_ready,
  output logic               m_sof,
  output logic [3*PIX_W-1:0] m_rgb
);
  import cbm_pkg::*;

  localparam int DEPTH = 3;

  logic                          adv;
  logic                          sof_acc;
  logic [TBL_W-1:0]              act_tbl;
  logic [TBL_W-1:0]              use_tbl;
  logic [TBL_W-1:0]              rd_tbl;
  logic                          fwd;
  logic                          defer;
  logic [DEPTH-1:0]              vld_q;
  logic [DEPTH-1:0]              sof_q;
  logic [N_CH-1:0][PIX_W-1:0]    pix;
  logic [N_CH-1:0][COEF_W-1:0]   coef [N_CH];
  logic [PIX_W-1:0]              res  [N_CH];

  // Whole pipeline steps together unless a result is parked at the output
  assign adv     = !vld_q[DEPTH-1] || m_ready;
  assign s_ready = adv;
  assign sof_acc = s_valid && adv && s_sof;

  // Table for the pixel at the input, and for write deferral this cycle
  assign use_tbl = sof_acc ? tbl_sel : act_tbl;
  assign rd_tbl  = s_sof ? tbl_sel : act_tbl;
  assign fwd     = sof_acc && (tbl_sel == act_tbl);
  assign defer   = (cw_tbl == use_tbl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_tbl <= '0;
      vld_q   <= '0;
      sof_q   <= '0;
    end else begin
      if (sof_acc) act_tbl <= tbl_sel;
      if (adv) begin
        vld_q <= {vld_q[DEPTH-2:0], s_valid};
        sof_q <= {sof_q[DEPTH-2:0], s_valid && s_sof};
      end
    end
  end

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_unpack
      assign pix[c] = s_rgb[(N_CH-1-c)*PIX_W +: PIX_W];
      assign m_rgb[(N_CH-1-c)*PIX_W +: PIX_W] = res[c];
    end

    for (genvar r = 0; r < N_CH; r++) begin : g_row
      cbm_coef_row #(
        .ROW    (r),
        .COEF_W (COEF_W),
        .FRAC   (FRAC),
        .N_TBL  (N_TBL),
        .TBL_W  (TBL_W)
      ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_tbl  (rd_tbl),
        .fwd     (fwd),
        .commit  (sof_acc),
        .act_tbl (act_tbl),
        .wr_en   (cw_en && (cw_row == 2'(r))),
        .defer   (defer),
        .wr_tbl  (cw_tbl),
        .wr_col  (cw_col),
        .wr_data (cw_data),
        .coef_o  (coef[r])
      );

      cbm_dot_row #(
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W),
        .FRAC   (FRAC)
      ) i_dot (
        .clk    (clk),
        .adv    (adv),
        .pix_i  (pix),
        .coef_i (coef[r]),
        .out_o  (res[r])
      );
    end
  endgenerate

  assign m_valid = vld_q[DEPTH-1];
  assign m_sof   = sof_q[DEPTH-1];
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int PIX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_valid,
  input logic               s_ready,
  input logic               m_valid,
  input logic               m_ready,
  input logic               m_sof,
  input logic [3*PIX_W-1:0] m_rgb
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_rgb) && $stable(m_sof))); // R6

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R6

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 2'd3) && $past(s_valid && s_ready, 3) && $past(s_ready, 2)
     && $past(s_ready, 1)) |-> m_valid); // R5

  AST_SOF_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    m_sof |-> m_valid); // R5

  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready); // R11
endmodule

bind colour_balance_matrix cbm_checker #(.PIX_W(PIX_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_sof   (m_sof),
  .m_rgb   (m_rgb)
);

// File: tb/test_colour_balance_matrix.sv
module test_colour_balance_matrix;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  tbl_sel;
  logic        cw_en;
  logic [5:0]  cw_tbl;
  logic [1:0]  cw_row;
  logic [1:0]  cw_col;
  logic [15:0] cw_data;
  logic        s_valid;
  logic        s_ready;
  logic        s_sof;
  logic [23:0] s_rgb;
  logic        m_valid;
  logic        m_ready;
  logic        m_sof;
  logic [23:0] m_rgb;

  int checks = 0;
  int errors = 0;
  int stalls = 0;
  logic [24:0] exp_q[$];
  string       req_q[$];

  int m_id[9] = '{4096, 0, 0, 0, 4096, 0, 0, 0, 4096};
  int m5[9]   = '{2048, 1024, 1024, -2048, 6144, 0, 512, 0, 4096};
  int m5b[9]  = '{2048, 1024, 1024, -2048, 6144, 0, 512, 0, 0};
  int m6[9]   = '{2048, 0, 0, 0, 2048, 0, -2048, 0, 4096};
  int m7[9]   = '{8192, 0, 0, 0, -4096, 0, 0, 0, 4096};

  always #(CLK_P/2) clk = ~clk;

  colour_balance_matrix i_colour_balance_matrix (
    .clk(clk), .rst_n(rst_n), .tbl_sel(tbl_sel), .cw_en(cw_en),
    .cw_tbl(cw_tbl), .cw_row(cw_row), .cw_col(cw_col), .cw_data(cw_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_rgb(s_rgb),
    .m_valid(m_valid), .m_ready(m_ready), .m_sof(m_sof), .m_rgb(m_rgb)
  );

  function automatic logic [24:0] model(input int m[9], input logic [23:0] px,
                                        input logic sof);
    int comp[3];
    logic [23:0] o;
    comp[0] = int'(px[23:16]); comp[1] = int'(px[15:8]); comp[2] = int'(px[7:0]);
    for (int r = 0; r < 3; r++) begin
      int s = 0;
      int v;
      for (int c = 0; c < 3; c++) s += m[r*3+c] * comp[c];
      v = (s + 2048) >>> 12;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      o[(2-r)*8 +: 8] = v[7:0];
    end
    return {sof, o};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Output monitor: compares every delivered pixel against the queue
  always @(negedge clk) begin
    #2;
    if (rst_n && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected output", {7'd0, m_sof, m_rgb}, 32'hFFFF_FFFF);
      end else begin
        logic [24:0] e;
        string       r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, {7'd0, m_sof, m_rgb}, {7'd0, e});
      end
    end
  end

  task automatic send(input logic [23:0] px, input logic sof, input int m[9],
                      input string req);
    s_valid = 1'b1; s_sof = sof; s_rgb = px;
    #1;
    while (!s_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    exp_q.push_back(model(m, px, sof));
    req_q.push_back(req);
    @(negedge clk);
  endtask

  task automatic idle();
    s_valid = 1'b0; s_sof = 1'b0;
  endtask

  task automatic wr(input int t, input int r, input int c, input int v);
    cw_en = 1'b1; cw_tbl = t[5:0]; cw_row = r[1:0]; cw_col = c[1:0];
    cw_data = v[15:0];
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic load(input int t, input int m[9]);
    for (int i = 0; i < 9; i++) wr(t, i / 3, i % 3, m[i]);
  endtask

  task automatic drain();
    idle();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    check("R6 drain empty", exp_q.size(), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset m_valid", {31'd0, m_valid}, 0);
    check("R1 reset s_ready", {31'd0, s_ready}, 1);
  endtask

  task automatic t_identity();
    tbl_sel = 6'd0;
    send(24'h0A141E, 1'b1, m_id, "R1 identity t0");
    send(24'hFF0080, 1'b0, m_id, "R1 identity t0");
    send(24'h00FF01, 1'b0, m_id, "R1 identity t0");
    tbl_sel = 6'd63;
    send(24'h010203, 1'b1, m_id, "R1 identity t63");
    send(24'hFEDCBA, 1'b0, m_id, "R1 identity t63");
    drain();
  endtask

  task automatic t_matrix();
    load(5, m5);  // table 63 in use, so table 5 is written at once (R8)
    tbl_sel = 6'd5;
    send(24'h643219, 1'b1, m5, "R2 R8 matrix");
    send(24'hFFFFFF, 1'b0, m5, "R2 matrix");
    send(24'h000000, 1'b0, m5, "R2 matrix");
    send({8'd7, 8'd9, 8'd200}, 1'b0, m5, "R2 matrix");
    drain();
  endtask

  task automatic t_round();
    wr(6, 0, 0, 2048); wr(6, 1, 1, 2048); wr(6, 2, 0, -2048);
    tbl_sel = 6'd6;
    send({8'd1, 8'd5, 8'd10}, 1'b1, m6, "R3 half up");
    send({8'd3, 8'd2, 8'd10}, 1'b0, m6, "R3 half up");
    send({8'd2, 8'd1, 8'd0},  1'b0, m6, "R3 half up");
    send({8'd1, 8'd0, 8'd0},  1'b0, m6, "R3 negative half");
    drain();
  endtask

  task automatic t_clamp();
    wr(7, 0, 0, 8192); wr(7, 1, 1, -4096);
    tbl_sel = 6'd7;
    send({8'd200, 8'd100, 8'd50}, 1'b1, m7, "R4 clamp");
    send({8'd128, 8'd0, 8'd7},    1'b0, m7, "R4 clamp top");
    send({8'd127, 8'd1, 8'd255},  1'b0, m7, "R4 clamp edge");
    drain();
  endtask

  task automatic t_select();
    tbl_sel = 6'd5;
    send({8'd40, 8'd80, 8'd120}, 1'b0, m7, "R7 no switch mid frame");
    send({8'd90, 8'd10, 8'd20},  1'b0, m7, "R7 no switch mid frame");
    send({8'd40, 8'd80, 8'd120}, 1'b1, m5, "R7 switch at sof");
    tbl_sel = 6'd7;
    send({8'd90, 8'd10, 8'd20},  1'b0, m5, "R7 no switch mid frame");
    drain();
  endtask

  task automatic t_defer();
    tbl_sel = 6'd5;
    wr(5, 2, 2, 0);
    send({8'd10, 8'd20, 8'd30}, 1'b0, m5,  "R9 held back");
    send({8'd10, 8'd20, 8'd30}, 1'b1, m5b, "R9 applied at sof");
    send({8'd60, 8'd70, 8'd80}, 1'b0, m5b, "R9 applied after");
    drain();
  endtask

  task automatic t_ignore();
    wr(0, 3, 0, 8192); wr(0, 0, 3, 8192); wr(0, 1, 3, -4096);
    tbl_sel = 6'd0;
    send({8'd50, 8'd60, 8'd70}, 1'b1, m_id, "R10 row col 3 ignored");
    send({8'd255, 8'd1, 8'd2},  1'b0, m_id, "R10 row col 3 ignored");
    drain();
  endtask

  task automatic t_latency();
    m_ready = 1'b1;
    s_valid = 1'b1; s_sof = 1'b1; s_rgb = 24'h112233;
    exp_q.push_back(model(m_id, 24'h112233, 1'b1));
    req_q.push_back("R5 latency data");
    @(negedge clk); idle(); #3;
    check("R5 latency cycle 1", {31'd0, m_valid}, 0);
    @(negedge clk); #3;
    check("R5 latency cycle 2", {31'd0, m_valid}, 0);
    @(negedge clk); #3;
    check("R5 latency cycle 3", {30'd0, m_valid, m_sof}, 3);
    drain();
  endtask

  task automatic t_throughput();
    stalls = 0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b = 8'(i * 13);
      send({b, ~b, 8'(i)}, (i == 0), m_id, "R11 streaming data");
    end
    check("R11 no stall", stalls, 0);
    drain();
  endtask

  task automatic t_backpressure();
    logic [23:0] held;
    m_ready = 1'b0;
    send(24'hA0B0C0, 1'b0, m_id, "R6 order");
    send(24'h102030, 1'b0, m_id, "R6 order");
    send(24'h405060, 1'b0, m_id, "R6 order");
    idle(); #1;
    check("R6 ready low", {31'd0, s_ready}, 0);
    held = m_rgb;
    check("R6 held data", {8'd0, held}, {8'd0, 24'hA0B0C0});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R6 stable valid", {31'd0, m_valid}, 1);
      check("R6 stable data", {8'd0, m_rgb}, {8'd0, held});
    end
    m_ready = 1'b1;
    drain();
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tbl_sel = '0; cw_en = 1'b0; cw_tbl = '0; cw_row = '0;
    cw_col = '0; cw_data = '0; s_valid = 1'b0; s_sof = 1'b0; s_rgb = '0;
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk);
    t_identity();
    t_matrix();
    t_round();
    t_clamp();
    t_select();
    t_defer();
    t_ignore();
    t_latency();
    t_throughput();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule